// File: doc/BRIEF.md
# RAM Scan-Test Wrapper

This block wraps a behavioural synchronous single-port memory that has separate write and read data buses. In normal operation it behaves as a plain RAM: a write strobe stores the write word at the addressed location on the clock edge, and the read word for an address presented in one cycle appears registered after the next edge. The output enable gates the read bus.

When the test-mode input is high, a two-bit mode field selects how the memory is handled during scan testing. Each mode keeps the logic in front of and behind the memory controllable or observable, instead of removing the memory altogether. The four choices are: silence the read bus; drive the read bus from the address and write strobe; pass the write word straight through to the read bus; or read previously loaded contents with all writes suppressed. In the last mode the read address may be folded onto a low window of the memory, so a partial initialisation is enough.

Top module: `ram_scan_wrap`

## Requirements
- R1: While reset is asserted the read bus is all zeros.
- R2: With test mode low, a write strobe stores the write word at the addressed location on the rising edge, and the word at the address present before an edge appears on the read bus after that edge (old contents when a write hits the same location on the same edge).
- R3: With test mode low and output enable low, the read bus is all zeros.
- R4: With test mode high and mode 00 (isolate), the read bus is all zeros whatever the output enable; writes still reach the memory.
- R5: With test mode high and mode 01 (drive), the read bus carries the drive word without delay; by default this is the address repeated across the bus width, every bit inverted when the write strobe is high (address 5, strobe low gives 8'h55).
- R6: With test mode high and mode 10 (bypass), the read bus equals the write word in the same cycle.
- R7: With test mode high and mode 11 (preload), write strobes have no effect on the memory contents, while reads still return the stored words one cycle after the address.
- R8: In preload mode only the low 2^PRELOAD_AW words are addressed: the read address is taken modulo 2^PRELOAD_AW (default 4 words, so address 5 reads location 1).
- R9: When test mode returns low, full-range addressing and plain read/write behaviour resume at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the read register |
| addr | input | AW | Word address |
| wdata | input | DW | Write data bus |
| we | input | 1 | Write strobe |
| oe | input | 1 | Read output enable |
| test_mode | input | 1 | Scan-test mode active |
| mode_sel | input | 2 | Test handling: 00 isolate, 01 drive, 10 bypass, 11 preload |
| rdata | output | DW | Read data bus |

## Verification
A wrong memory word or a misdirected address shows on the read bus one edge after the affected address is presented, so every directed read compares against a shadow copy kept by the bench. A write that leaks through preload mode is invisible while the mode is held and only surfaces when the location is read back after test mode drops, so the bench reads the struck location both during and after preload. Drive and bypass faults are combinational and show in the same cycle the inputs change; the address fold shows as soon as a high address is read in preload mode.

// File: rtl/ram_scan_pkg.sv
package ram_scan_pkg;
   typedef enum logic [1:0] {
      TM_ISOLATE = 2'b00,
      TM_DRIVE   = 2'b01,
      TM_BYPASS  = 2'b10,
      TM_PRELOAD = 2'b11
   } tm_mode_e;
endpackage

// File: rtl/ram_core.sv
module ram_core #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_q
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= mem[addr];
   end
endmodule

// File: rtl/ram_addr_ctl.sv
module ram_addr_ctl
   import ram_scan_pkg::*;
#(
   parameter int AW     = 4,
   parameter int PRE_AW = 2
) (
   input  logic          test_mode,
   input  tm_mode_e      mode,
   input  logic          we,
   input  logic [AW-1:0] addr,
   output logic          core_we,
   output logic [AW-1:0] core_addr
);
   logic in_preload;
   assign in_preload = test_mode && (mode == TM_PRELOAD);
   assign core_we    = we && !in_preload;

   generate
      if (PRE_AW >= AW) begin : g_full
         assign core_addr = addr;
      end else begin : g_fold
         logic [AW-1:0] folded;
         assign folded    = {{(AW-PRE_AW){1'b0}}, addr[PRE_AW-1:0]};
         assign core_addr = in_preload ? folded : addr;
      end
   endgenerate
endmodule

// File: rtl/ram_out_sel.sv
module ram_out_sel
   import ram_scan_pkg::*;
#(
   parameter int          AW         = 4,
   parameter int          DW         = 8,
   parameter bit          DRIVE_CTRL = 1'b1,
   parameter logic [DW-1:0] DRIVE_VAL = '0
) (
   input  logic          test_mode,
   input  tm_mode_e      mode,
   input  logic          oe,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] rd_q,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] drv_word;

   generate
      if (DRIVE_CTRL) begin : g_ctrl_drive
         for (genvar i = 0; i < DW; i++) begin : g_bit
            assign drv_word[i] = addr[i % AW] ^ we;
         end
      end else begin : g_const_drive
         assign drv_word = DRIVE_VAL;
      end
   endgenerate

   always_comb begin
      if (!test_mode) begin
         rdata = oe ? rd_q : '0;
      end else begin
         unique case (mode)
            TM_ISOLATE: rdata = '0;
            TM_DRIVE:   rdata = drv_word;
            TM_BYPASS:  rdata = wdata;
            default:    rdata = oe ? rd_q : '0;
         endcase
      end
   end
endmodule

// File: rtl/ram_scan_wrap.sv
module ram_scan_wrap
   import ram_scan_pkg::*;
#(
   parameter int            AW         = 4,
   parameter int            DW         = 8,
   parameter int            PRE_AW     = 2,
   parameter bit            DRIVE_CTRL = 1'b1,
   parameter logic [DW-1:0] DRIVE_VAL  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          we,
   input  logic          oe,
   input  logic          test_mode,
   input  logic [1:0]    mode_sel,
   output logic [DW-1:0] rdata
);
   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("ram_scan_wrap: AW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("ram_scan_wrap: DW must be positive");
      end
      if (PRE_AW < 1 || PRE_AW > AW) begin : g_bad_pre
         $error("ram_scan_wrap: PRE_AW must lie in 1..AW");
      end
   endgenerate

   tm_mode_e      mode;
   logic          core_we;
   logic [AW-1:0] core_addr;
   logic [DW-1:0] rd_q;

   assign mode = tm_mode_e'(mode_sel);

   ram_addr_ctl #(.AW(AW), .PRE_AW(PRE_AW)) u_addr (
      .test_mode (test_mode),
      .mode      (mode),
      .we        (we),
      .addr      (addr),
      .core_we   (core_we),
      .core_addr (core_addr)
   );

   ram_core #(.AW(AW), .DW(DW)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (core_we),
      .addr  (core_addr),
      .wdata (wdata),
      .rd_q  (rd_q)
   );

   ram_out_sel #(.AW(AW), .DW(DW), .DRIVE_CTRL(DRIVE_CTRL), .DRIVE_VAL(DRIVE_VAL)) u_out (
      .test_mode (test_mode),
      .mode      (mode),
      .oe        (oe),
      .we        (we),
      .addr      (addr),
      .wdata     (wdata),
      .rd_q      (rd_q),
      .rdata     (rdata)
   );

   // R3
   oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !oe) |-> (rdata == '0));

   // R4
   isolate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && mode_sel == 2'b00) |-> (rdata == '0));

   // R6
   bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && mode_sel == 2'b10) |-> (rdata == wdata));

   // R7
   preload_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && mode_sel == 2'b11) |-> !core_we);

   // R8
   preload_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && mode_sel == 2'b11) |-> (core_addr < AW'(1 << PRE_AW) || PRE_AW == AW));
endmodule

// File: tb/test_ram_scan_wrap.sv
module test_ram_scan_wrap;
   localparam int AW = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          we = 1'b0;
   logic          oe = 1'b1;
   logic          test_mode = 1'b0;
   logic [1:0]    mode_sel = 2'b00;
   logic [DW-1:0] rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [DW-1:0] shadow [16];

   always #10 clk = ~clk;

   ram_scan_wrap i_ram_scan_wrap (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
      .oe(oe), .test_mode(test_mode), .mode_sel(mode_sel), .rdata(rdata)
   );

   task automatic check(input string req, input logic [DW-1:0] exp);
      n_run++;
      if (rdata !== exp) begin
         n_fail++;
         $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
      @(negedge clk);
      we = 1'b0; addr = a;
      @(negedge clk);
      #1 check(req, exp);
   endtask

   task automatic t_reset;
      @(negedge clk);
      #1 check("R1", '0);
   endtask

   task automatic t_func;
      for (int i = 0; i < 16; i++) begin
         wr(AW'(i), DW'(i * 17 + 3));
         shadow[i] = DW'(i * 17 + 3);
      end
      rd_chk(4'd0, shadow[0], "R2");
      rd_chk(4'd9, shadow[9], "R2");
      rd_chk(4'd15, shadow[15], "R2");
      // R2 read-before-write on the same edge
      @(negedge clk);
      addr = 4'd3; wdata = 8'hF0; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      #1 check("R2", shadow[3]);
      shadow[3] = 8'hF0;
      @(negedge clk);
      #1 check("R2", 8'hF0);
   endtask

   task automatic t_oe;
      oe = 1'b0;
      rd_chk(4'd7, '0, "R3");
      oe = 1'b1;
      #1 check("R3", shadow[7]);
   endtask

   task automatic t_isolate;
      test_mode = 1'b1; mode_sel = 2'b00;
      rd_chk(4'd2, '0, "R4");
      wr(4'd4, 8'h4E);
      shadow[4] = 8'h4E;
      #1 check("R4", '0);
      test_mode = 1'b0;
      rd_chk(4'd4, 8'h4E, "R4");
   endtask

   task automatic t_drive;
      test_mode = 1'b1; mode_sel = 2'b01;
      @(negedge clk);
      addr = 4'd5; we = 1'b0;
      #1 check("R5", 8'h55);
      @(negedge clk);
      addr = 4'd3; wdata = 8'h30; we = 1'b1;
      shadow[3] = 8'h30;
      #1 check("R5", 8'hCC);
      @(negedge clk);
      we = 1'b0;
      test_mode = 1'b0;
      rd_chk(4'd3, 8'h30, "R5");
   endtask

   task automatic t_bypass;
      test_mode = 1'b1; mode_sel = 2'b10;
      @(negedge clk);
      we = 1'b0; addr = 4'd1; wdata = 8'h3C;
      #1 check("R6", 8'h3C);
      @(negedge clk);
      wdata = 8'hC3;
      #1 check("R6", 8'hC3);
      test_mode = 1'b0;
   endtask

   task automatic t_preload;
      test_mode = 1'b1; mode_sel = 2'b11;
      wr(4'd1, 8'hEE);
      rd_chk(4'd1, shadow[1], "R7");
      rd_chk(4'd2, shadow[2], "R7");
      rd_chk(4'd5, shadow[1], "R8");
      rd_chk(4'd14, shadow[2], "R8");
      test_mode = 1'b0;
      rd_chk(4'd1, shadow[1], "R7");
      rd_chk(4'd5, shadow[5], "R9");
      rd_chk(4'd14, shadow[14], "R9");
      wr(4'd6, 8'h66);
      rd_chk(4'd6, 8'h66, "R9");
   endtask

   initial begin
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_func();
      t_oe();
      t_isolate();
      t_drive();
      t_bypass();
      t_preload();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule